// File: doc/BRIEF.md
# Compact 8-bit Multicycle Processor Core

This block is a small processor core that steps through fetch, decode and execute over several clock cycles. It works on eight 8-bit registers, a 12-bit byte address for the program counter and the stack pointer, and a one-bit condition flag. Each 16-bit instruction is read as two bytes through a single synchronous byte-wide memory port. Program and data share that port.

The instruction set covers arithmetic, logic, shift and rotate operations, comparisons, direct, immediate and register-indirect memory access, a stack, subroutine call and return, jumps and a counted loop. A separate combinational unit computes the data operations and comparisons. The core stops and raises `halt` when an executed instruction leaves the program counter where it was, for example a jump to its own address. It raises `err` when it sees a misaligned fetch or a nonzero value written to R0.

Top module: `byte_core`

## Requirements
- R1: After reset, `halt` and `err` are low, no memory write is requested, and the first fetch read is issued at address 0. All registers, the program counter, the stack pointer and the condition flag reset to zero.
- R2: An instruction word is read with its high byte from PC and its low byte from PC+1. Bits 15:11 are the opcode. The register fields are ra = 10:8, rb = 7:5 and rc = 4:2. The 8-bit constant or address field is 7:0, and the 11-bit address field is 10:0. Opcodes are numbered as follows: 0 nop; 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 not, 7 neg, 8 shiftr, 9 shiftl, 10 rotar, 11 rotal, 12 jmprind, 13 grt, 14 grteq, 15 eq, 16 neq, 17 loadrind, 18 storerind; 19 load, 20 loadim, 21 store, 22 addim, 23 subim, 24 push, 25 pop, 26 loop; 27 jmpaddr, 28 jcondaddr, 29 jcondrin, 30 call, 31 return.
- R3: Opcodes 1 to 11 write ra = f(rb, rc) modulo 256. The operations are sum, difference, AND, OR and XOR; not = bitwise complement of rb; neg = two's complement of rb. Logical shifts by rc give 0 when rc > 7. Rotates turn rb by rc mod 8 places.
- R4: grt, grteq, eq and neq compare ra with rb as unsigned numbers and set the condition flag. jcondaddr jumps to the 11-bit address, and jcondrin jumps to the value in ra, only when the flag is 1. Otherwise they continue at PC+2.
- R5: load reads ra from the byte at the 8-bit address. loadim places the constant in ra. store writes ra to the 8-bit address. loadrind reads ra from the address held in rb. storerind writes rb to the address held in ra. addim and subim add the constant to ra or subtract it, modulo 256. No cycle both reads and writes memory.
- R6: push decrements SP and then writes ra at SP. pop reads ra at SP and then increments SP. Both wrap modulo 4096. Reading R7 returns SP[7:0]. Writing R7 sets SP to the written value, zero-extended.
- R7: call lowers SP by 2. It writes {0000, PC[11:8]} at the new SP and PC[7:0] at SP+1, then jumps to the 11-bit address. return reads those two bytes, resumes at the saved PC + 2 and raises SP by 2.
- R8: loop decrements ra, saturating at 0. If the result is nonzero it jumps to the 8-bit address; otherwise it goes on to PC+2.
- R9: jmpaddr jumps to the 11-bit address and jmprind to the value in ra. When an executed instruction leaves PC unchanged, `halt` rises and stays high, and the core makes no further memory accesses.
- R10: A fall-through from PC 0xFFE leaves PC at 0xFFE, which halts the core.
- R11: A fetch at an odd PC sets `err`, moves PC down by one and fetches again from there.
- R12: R0 always reads zero. An instruction that writes a nonzero value to R0 sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Byte address for memory access |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's request |
| halt | output | 1 | Sticky: PC unchanged by an executed instruction |
| err | output | 1 | Sticky: odd fetch address or nonzero R0 write |

## Verification
The data operations are swept over every pairing of eight operand values chosen to hit the carry, the sign bit, all-ones and shift amounts below and above seven. This separates wrap-around, shift saturation and rotate direction. The four comparisons run over the same pairs, and each branches through one of the two conditional-jump kinds, so a flag error and a wrong jump target show up as different stored markers. The loop runs with start counts from 0 to 8, which tells the saturating zero case apart from ordinary counts. Directed programs cover the stack wrap below address 0, the R7/SP link, a call frame with a nonzero upper nibble, the fall-through at the top of memory, an odd jump target and a write to R0.

// File: rtl/byte_core.sv
module byte_core_alu (
  input  logic [4:0] op,
  input  logic [7:0] p,
  input  logic [7:0] q,
  output logic [7:0] y,
  output logic       flag
);
  logic [15:0] dbl;
  assign dbl = {p, p};

  always_comb begin
    y = 8'h00;
    flag = 1'b0;
    case (op)
      5'd1:  y = p + q;
      5'd2:  y = p - q;
      5'd3:  y = p & q;
      5'd4:  y = p | q;
      5'd5:  y = p ^ q;
      5'd6:  y = ~p;
      5'd7:  y = 8'h00 - p;
      5'd8:  y = (q > 8'd7) ? 8'h00 : (p >> q[2:0]);
      5'd9:  y = (q > 8'd7) ? 8'h00 : (p << q[2:0]);
      5'd10: y = 8'(dbl >> q[2:0]);
      5'd11: y = 8'((dbl << q[2:0]) >> 8);
      5'd13: flag = p > q;
      5'd14: flag = p >= q;
      5'd15: flag = p == q;
      5'd16: flag = p != q;
      default: ;
    endcase
  end
endmodule

module byte_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [11:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        halt,
  output logic        err
);
  localparam logic [4:0] OP_NOP = 5'd0,  OP_JRI = 5'd12, OP_LDRI = 5'd17,
                         OP_STRI = 5'd18, OP_LD = 5'd19, OP_LDI = 5'd20,
                         OP_ST = 5'd21, OP_ADDI = 5'd22, OP_SUBI = 5'd23,
                         OP_PUSH = 5'd24, OP_POP = 5'd25, OP_LOOP = 5'd26,
                         OP_JA = 5'd27, OP_JCA = 5'd28, OP_JCR = 5'd29,
                         OP_CALL = 5'd30, OP_RET = 5'd31;

  typedef enum logic [3:0] {S_F0, S_F1, S_F2, S_EX, S_WB, S_R1, S_R2, S_C1, S_HALT} st_t;

  st_t         st, st_n;
  logic [11:0] pc, sp, npc, seq;
  logic [15:0] ir;
  logic [3:0]  tmp;
  logic        cond, commit, cond_we;
  logic [7:0]  rf [0:7];
  logic        rf_we, sp_we;
  logic [2:0]  rf_wa;
  logic [7:0]  rf_wd;
  logic [11:0] sp_wd;

  logic [4:0]  op;
  logic [2:0]  ra, rb, rc;
  logic [7:0]  imm, va, vb, vc, dec, alu_p, alu_q, alu_y;
  logic [10:0] a11;
  logic        alu_f, is_cmp;
  logic        unused_bits;

  assign op  = ir[15:11];
  assign ra  = ir[10:8];
  assign rb  = ir[7:5];
  assign rc  = ir[4:2];
  assign imm = ir[7:0];
  assign a11 = ir[10:0];
  assign unused_bits = ^ir[1:0];

  assign va = (ra == 3'd7) ? sp[7:0] : rf[ra];
  assign vb = (rb == 3'd7) ? sp[7:0] : rf[rb];
  assign vc = (rc == 3'd7) ? sp[7:0] : rf[rc];

  assign is_cmp = (op >= 5'd13) && (op <= 5'd16);
  assign alu_p  = is_cmp ? va : vb;
  assign alu_q  = is_cmp ? vb : vc;
  assign dec    = (va == 8'h00) ? 8'h00 : va - 8'h01;
  assign seq    = (pc >= 12'hFFE) ? pc : pc + 12'd2;

  byte_core_alu alu_i (.op(op), .p(alu_p), .q(alu_q), .y(alu_y), .flag(alu_f));

  always_comb begin
    st_n = st;
    commit = 1'b0;
    npc = seq;
    mem_addr = pc;
    mem_rd = 1'b0;
    mem_we = 1'b0;
    mem_wdata = 8'h00;
    rf_we = 1'b0;
    rf_wa = ra;
    rf_wd = alu_y;
    sp_we = 1'b0;
    sp_wd = sp;
    cond_we = 1'b0;
    case (st)
      S_F0: begin
        mem_rd = !pc[0];
        st_n = pc[0] ? S_F0 : S_F1;
      end
      S_F1: begin
        mem_addr = pc + 12'd1;
        mem_rd = 1'b1;
        st_n = S_F2;
      end
      S_F2: st_n = S_EX;
      S_EX: begin
        case (op)
          OP_NOP: commit = 1'b1;
          OP_JRI: begin commit = 1'b1; npc = {4'h0, va}; end
          OP_LDRI: begin mem_addr = {4'h0, vb}; mem_rd = 1'b1; st_n = S_WB; end
          OP_STRI: begin
            mem_addr = {4'h0, va}; mem_we = 1'b1; mem_wdata = vb; commit = 1'b1;
          end
          OP_LD: begin mem_addr = {4'h0, imm}; mem_rd = 1'b1; st_n = S_WB; end
          OP_LDI: begin rf_we = 1'b1; rf_wd = imm; commit = 1'b1; end
          OP_ST: begin
            mem_addr = {4'h0, imm}; mem_we = 1'b1; mem_wdata = va; commit = 1'b1;
          end
          OP_ADDI: begin rf_we = 1'b1; rf_wd = va + imm; commit = 1'b1; end
          OP_SUBI: begin rf_we = 1'b1; rf_wd = va - imm; commit = 1'b1; end
          OP_PUSH: begin
            sp_we = 1'b1; sp_wd = sp - 12'd1;
            mem_addr = sp - 12'd1; mem_we = 1'b1; mem_wdata = va; commit = 1'b1;
          end
          OP_POP: begin mem_addr = sp; mem_rd = 1'b1; st_n = S_WB; end
          OP_LOOP: begin
            rf_we = 1'b1; rf_wd = dec; commit = 1'b1;
            npc = (dec != 8'h00) ? {4'h0, imm} : seq;
          end
          OP_JA: begin commit = 1'b1; npc = {1'b0, a11}; end
          OP_JCA: begin commit = 1'b1; npc = cond ? {1'b0, a11} : seq; end
          OP_JCR: begin commit = 1'b1; npc = cond ? {4'h0, va} : seq; end
          OP_CALL: begin
            mem_addr = sp - 12'd2; mem_we = 1'b1; mem_wdata = {4'h0, pc[11:8]};
            st_n = S_C1;
          end
          OP_RET: begin mem_addr = sp; mem_rd = 1'b1; st_n = S_R1; end
          default: begin
            commit = 1'b1;
            if (is_cmp) cond_we = 1'b1;
            else rf_we = 1'b1;
          end
        endcase
      end
      S_WB: begin
        rf_we = 1'b1;
        rf_wd = mem_rdata;
        if (op == OP_POP) begin sp_we = 1'b1; sp_wd = sp + 12'd1; end
        commit = 1'b1;
      end
      S_R1: begin
        mem_addr = sp + 12'd1;
        mem_rd = 1'b1;
        st_n = S_R2;
      end
      S_R2: begin
        commit = 1'b1;
        npc = {tmp, mem_rdata} + 12'd2;
        sp_we = 1'b1;
        sp_wd = sp + 12'd2;
      end
      S_C1: begin
        mem_addr = sp - 12'd1;
        mem_we = 1'b1;
        mem_wdata = pc[7:0];
        sp_we = 1'b1;
        sp_wd = sp - 12'd2;
        commit = 1'b1;
        npc = {1'b0, a11};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else if (rf_we && rf_wa != 3'd0 && rf_wa != 3'd7) begin
      rf[rf_wa] <= rf_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_F0;
      pc <= 12'h000;
      sp <= 12'h000;
      ir <= 16'h0000;
      tmp <= 4'h0;
      cond <= 1'b0;
      halt <= 1'b0;
      err <= 1'b0;
    end else begin
      if (st == S_F0 && pc[0]) begin
        pc <= pc - 12'd1;
        err <= 1'b1;
      end
      if (st == S_F1) ir[15:8] <= mem_rdata;
      if (st == S_F2) ir[7:0] <= mem_rdata;
      if (st == S_R1) tmp <= mem_rdata[3:0];
      if (cond_we) cond <= alu_f;
      if (rf_we && rf_wa == 3'd0 && rf_wd != 8'h00) err <= 1'b1;
      if (rf_we && rf_wa == 3'd7) sp <= {4'h0, rf_wd};
      else if (sp_we) sp <= sp_wd;
      if (commit) begin
        pc <= npc;
        if (npc == pc) begin
          halt <= 1'b1;
          st <= S_HALT;
        end else begin
          st <= S_F0;
        end
      end else begin
        st <= st_n;
      end
    end
  end

  // R5
  no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_we));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(pc)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mem_rd && !mem_we));

  // R11
  odd_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F0 && pc[0]) |=> (err && pc == $past(pc) - 12'd1));

  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EX && op == OP_PUSH) |=> (sp == $past(sp) - 12'd1));
endmodule

// File: tb/byte_core_tb.sv
module byte_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_we, halt, err;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [0:4095];
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  byte_core dut_i (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
                   .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
                   .halt(halt), .err(err));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog (R1..all): actual %0d cycles expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] e1(int op, int a, int b, int c);
    return {op[4:0], a[2:0], b[2:0], c[2:0], 2'b00};
  endfunction
  function automatic logic [15:0] e2(int op, int a, int k);
    return {op[4:0], a[2:0], k[7:0]};
  endfunction
  function automatic logic [15:0] e3(int op, int adr);
    return {op[4:0], adr[10:0]};
  endfunction

  task automatic put(input int adr, input logic [15:0] w);
    mem[adr] = w[15:8];
    mem[adr + 1] = w[7:0];
  endtask

  task automatic clr();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input string req);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halt) break;
    end
    chk({req, " halted"}, int'(halt), 1);
  endtask

  function automatic int ref_alu(int op, int a, int b);
    int n = b % 8;
    case (op)
      1: return (a + b) & 255;
      2: return (a - b) & 255;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return 255 - a;
      7: return (256 - a) & 255;
      8: return (b > 7) ? 0 : (a >> b);
      9: return (b > 7) ? 0 : ((a << b) & 255);
      10: return ((a >> n) | (a << (8 - n))) & 255;
      default: return ((a << n) | (a >> (8 - n))) & 255;
    endcase
  endfunction

  function automatic int ref_cmp(int op, int a, int b);
    case (op)
      13: return int'(a > b);
      14: return int'(a >= b);
      15: return int'(a == b);
      default: return int'(a != b);
    endcase
  endfunction

  int vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h03, 8'h08, 8'hA5};

  initial begin
    @(negedge clk);
    // R1: state while held in reset and right after release
    chk("R1 halt", int'(halt), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 we", int'(mem_we), 0);
    rst_n = 1'b1;
    chk("R1 first fetch addr", int'(mem_addr), 0);
    chk("R1 first fetch rd", int'(mem_rd), 1);

    // R3, R2: data operations swept over operand pairs
    for (int op = 1; op <= 11; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          clr();
          put(0, e2(20, 1, vals[i]));
          put(2, e2(20, 2, vals[j]));
          put(4, e1(op, 3, 1, 2));
          put(6, e2(21, 3, 8'h80));
          put(8, e3(27, 8));
          run("R3");
          chk($sformatf("R3 op%0d a=%0h b=%0h", op, vals[i], vals[j]),
              int'(mem[8'h80]), ref_alu(op, vals[i], vals[j]));
        end

    // R4: comparisons feeding both conditional jumps
    for (int op = 13; op <= 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          clr();
          put(0, e2(20, 1, vals[i]));
          put(2, e2(20, 2, vals[j]));
          put(4, e2(20, 4, 8'h20));
          put(6, e1(op, 1, 2, 0));
          put(8, (op < 15) ? e3(28, 12'h020) : e3(29, 4 << 8));
          put(10, e2(20, 3, 8'h11));
          put(12, e2(21, 3, 8'h80));
          put(14, e3(27, 14));
          put(12'h20, e2(20, 3, 8'h22));
          put(12'h22, e2(21, 3, 8'h80));
          put(12'h24, e3(27, 12'h24));
          run("R4");
          chk($sformatf("R4 op%0d a=%0h b=%0h", op, vals[i], vals[j]), int'(mem[8'h80]),
              ref_cmp(op, vals[i], vals[j]) != 0 ? 8'h22 : 8'h11);
        end

    // R5: direct, immediate and indirect accesses
    clr();
    put(0, e2(20, 1, 8'h5A));
    put(2, e2(21, 1, 8'h90));
    put(4, e2(19, 2, 8'h90));
    put(6, e2(20, 3, 8'h91));
    put(8, e1(18, 3, 2, 0));
    put(10, e1(17, 4, 3, 0));
    put(12, e2(22, 4, 8'h10));
    put(14, e2(21, 4, 8'h92));
    put(16, e2(23, 4, 8'h20));
    put(18, e2(21, 4, 8'h93));
    put(20, e3(27, 20));
    run("R5");
    chk("R5 store", int'(mem[8'h90]), 8'h5A);
    chk("R5 storerind", int'(mem[8'h91]), 8'h5A);
    chk("R5 loadrind+addim", int'(mem[8'h92]), 8'h6A);
    chk("R5 subim", int'(mem[8'h93]), 8'h4A);
    chk("R5 no err", int'(err), 0);

    // R6: stack wrap below zero and the R7/SP link
    clr();
    put(0, e2(20, 1, 8'h11));
    put(2, e2(24, 1, 0));
    put(4, e2(21, 7, 8'h80));
    put(6, e2(25, 2, 0));
    put(8, e2(21, 2, 8'h81));
    put(10, e2(21, 7, 8'h82));
    put(12, e2(20, 7, 8'h40));
    put(14, e2(24, 1, 0));
    put(16, e2(21, 7, 8'h83));
    put(18, e3(27, 18));
    run("R6");
    chk("R6 push wrap data", int'(mem[12'hFFF]), 8'h11);
    chk("R6 r7 after push", int'(mem[8'h80]), 8'hFF);
    chk("R6 pop data", int'(mem[8'h81]), 8'h11);
    chk("R6 r7 after pop", int'(mem[8'h82]), 8'h00);
    chk("R6 push after r7 write", int'(mem[8'h3F]), 8'h11);
    chk("R6 r7 after second push", int'(mem[8'h83]), 8'h3F);

    // R7: call frame with nonzero upper nibble, and return
    clr();
    put(0, e2(20, 7, 8'hA0));
    put(2, e3(27, 12'h3F0));
    put(12'h3F0, e3(30, 12'h100));
    put(12'h3F2, e2(21, 1, 8'h80));
    put(12'h3F4, e2(21, 7, 8'h81));
    put(12'h3F6, e3(27, 12'h3F6));
    put(12'h100, e2(20, 1, 8'h77));
    put(12'h102, e3(31, 0));
    run("R7");
    chk("R7 frame high", int'(mem[8'h9E]), 8'h03);
    chk("R7 frame low", int'(mem[8'h9F]), 8'hF0);
    chk("R7 resumed after call", int'(mem[8'h80]), 8'h77);
    chk("R7 sp restored", int'(mem[8'h81]), 8'hA0);

    // R8: counted loop including the saturating zero start
    for (int n = 0; n <= 8; n++) begin
      clr();
      put(0, e2(20, 1, n));
      put(2, e2(20, 2, 0));
      put(4, e2(22, 2, 1));
      put(6, e2(26, 1, 8'h04));
      put(8, e2(21, 2, 8'h80));
      put(10, e2(21, 1, 8'h81));
      put(12, e3(27, 12));
      run("R8");
      chk($sformatf("R8 passes n=%0d", n), int'(mem[8'h80]), (n == 0) ? 1 : n);
      chk($sformatf("R8 final count n=%0d", n), int'(mem[8'h81]), 0);
    end

    // R9: register jump, then halt stays quiet
    clr();
    put(0, e2(20, 1, 8'h10));
    put(2, e1(12, 1, 0, 0));
    put(4, e2(21, 1, 8'h84));
    put(12'h10, e2(21, 1, 8'h80));
    put(12'h12, e3(27, 12'h12));
    run("R9");
    chk("R9 jmprind target", int'(mem[8'h80]), 8'h10);
    chk("R9 skipped slot", int'(mem[8'h84]), 8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 halt sticky", int'(halt), 1);
      chk("R9 no access after halt", int'(mem_rd | mem_we), 0);
    end

    // R10: fall-through at the top of memory
    clr();
    mem[12'h040] = 8'h0F;
    mem[12'h041] = 8'hFC;
    put(0, e2(20, 7, 8'h40));
    put(2, e3(31, 0));
    put(12'hFFE, e2(21, 7, 8'h80));
    run("R10");
    chk("R10 executed at FFE", int'(mem[8'h80]), 8'h42);
    chk("R10 no err", int'(err), 0);

    // R11: odd jump target
    clr();
    put(0, e2(20, 1, 8'h11));
    put(2, e1(12, 1, 0, 0));
    put(12'h10, e2(21, 1, 8'h80));
    put(12'h12, e3(27, 12'h12));
    run("R11");
    chk("R11 err", int'(err), 1);
    chk("R11 refetch at even", int'(mem[8'h80]), 8'h11);

    // R12: write to R0
    clr();
    put(0, e2(20, 0, 8'h55));
    put(2, e2(21, 0, 8'h80));
    put(4, e2(20, 1, 8'h66));
    put(6, e2(21, 1, 8'h81));
    put(8, e3(27, 8));
    run("R12");
    chk("R12 r0 reads zero", int'(mem[8'h80]), 8'h00);
    chk("R12 err", int'(err), 1);
    chk("R12 later code runs", int'(mem[8'h81]), 8'h66);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule